// File: doc/BRIEF.md
# Second-Order Carrier Phase Oscillator

This block generates the local carrier used to strip the residual carrier from incoming samples before they are correlated. It keeps a signed phase word in which the full 32-bit range spans one turn: zero is zero radians and 2^31 stands for pi. A signed step and a signed step-rate, in the same scaling, are captured together with a starting phase on a single start pulse. That pulse is the one that launches the correlation run.

Each time the sample path accepts a sample, the phase moves forward by the current step. The step then moves by the rate. A non-zero rate therefore yields a linear frequency ramp, which lets the block follow Doppler dynamics within one integration. The phase word is available to the mixer, together with a small signed cosine/sine pair taken from a table that stores one quarter of a wave.

Top module: `ncoCarrier`

## Requirements
- R1: After reset the phase, step and rate registers are zero, so phaseOut reads 0.
- R2: A high startPulse at a clock edge loads initPhase, initStep and stepRate, visible from the next cycle. A start pulse takes priority over sampleValid in the same cycle.
- R3: On an edge with sampleValid high and startPulse low, the phase becomes phase + step modulo 2^32. A phase that passes +pi (0x7FFFFFFF) continues from -pi (0x80000000).
- R4: On an edge with both sampleValid and startPulse low, the phase and the step both keep their values.
- R5: On every accepted sample, the phase update of R3 uses the step as it was before that edge. The step then becomes step + rate modulo 2^32, so the phase after n samples from a load is p0 + n*s0 + r*n*(n-1)/2.
- R6: With L = LUT_BITS, the table index is the unsigned value of phaseOut[31:32-L]. sinOut equals round(127*sin(2*pi*(idx+0.5)/2^L)), and cosOut equals the same expression with cos. Rounding is half away from zero, and both are 8-bit two's complement.
- R7: Neither sinOut nor cosOut ever takes the value -128 (0x80).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Loads initial phase, step and rate |
| sampleValid | input | 1 | One accepted input sample this cycle |
| initPhase | input | 32 | Signed starting phase, 2^31 = pi |
| initStep | input | 32 | Signed phase increment per sample |
| stepRate | input | 32 | Signed increment of the step per sample |
| phaseOut | output | 32 | Current signed phase |
| cosOut | output | 8 | Signed cosine of the phase |
| sinOut | output | 8 | Signed sine of the phase |

## Verification
The assertions assume that startPulse and sampleValid hold known values at every clock edge once reset is released. They also assume that the load inputs are stable around the edge on which startPulse is high. The bench meets both assumptions by changing every input only on the falling clock edge and by holding the load values steady for the cycle of the pulse. Phase values near the wrap point and negative steps and rates are chosen on purpose. Wrap-around is an expected behaviour, and no assertion treats it as an error.

// File: rtl/ncoPkg.sv
package ncoPkg;
  typedef struct packed {
    logic load;
    logic advance;
  } ncoStrobes_t;
endpackage

// File: rtl/ncoCtrl.sv
module ncoCtrl
  import ncoPkg::*;
(
  input  logic        startPulse,
  input  logic        sampleValid,
  output ncoStrobes_t strobes
);
  // a start pulse wins over a sample in the same cycle
  always_comb begin
    strobes.load    = startPulse;
    strobes.advance = sampleValid & ~startPulse;
  end
endmodule

// File: rtl/ncoPhaseDp.sv
module ncoPhaseDp
  import ncoPkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ncoStrobes_t        strobes,
  input  logic [PHASE_W-1:0] initPhase,
  input  logic [PHASE_W-1:0] initStep,
  input  logic [PHASE_W-1:0] stepRate,
  output logic [PHASE_W-1:0] phaseQ,
  output logic [PHASE_W-1:0] stepQ,
  output logic [PHASE_W-1:0] rateQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      stepQ  <= '0;
      rateQ  <= '0;
    end else if (strobes.load) begin
      phaseQ <= initPhase;
      stepQ  <= initStep;
      rateQ  <= stepRate;
    end else if (strobes.advance) begin
      // phase consumes the old step; step then moves by the rate
      phaseQ <= phaseQ + stepQ;
      stepQ  <= stepQ + rateQ;
    end
  end
endmodule

// File: rtl/ncoSinCos.sv
module ncoSinCos #(
  parameter int PHASE_W  = 32,
  parameter int LUT_BITS = 6,
  parameter int AMP_W    = 8
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [AMP_W-1:0]   cosOut,
  output logic [AMP_W-1:0]   sinOut
);
  localparam int  QUARTER = 2 ** (LUT_BITS - 2);
  localparam int  OFF_W   = LUT_BITS - 2;
  localparam real AMP     = real'(2 ** (AMP_W - 1) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic [AMP_W-1:0]    quarterMag [QUARTER];
  logic [LUT_BITS-1:0] sinIdx;
  logic [LUT_BITS-1:0] cosIdx;

  // quarter-wave magnitudes sampled at bin centres, so the folds are exact
  for (genvar k = 0; k < QUARTER; k++) begin : g_mag
    localparam real ANG = HALF_PI * (real'(k) + 0.5) / real'(QUARTER);
    localparam int  MAG = $rtoi($floor(AMP * $sin(ANG) + 0.5));
    assign quarterMag[k] = AMP_W'(MAG);
  end

  function automatic logic [AMP_W-1:0] foldLookup(input logic [LUT_BITS-1:0] idx);
    logic [OFF_W-1:0] off;
    logic [AMP_W-1:0] mag;
    off = idx[LUT_BITS-2] ? ~idx[OFF_W-1:0] : idx[OFF_W-1:0];
    mag = quarterMag[off];
    return idx[LUT_BITS-1] ? (~mag + 1'b1) : mag;
  endfunction

  always_comb begin
    sinIdx = phase[PHASE_W-1 -: LUT_BITS];
    cosIdx = sinIdx + LUT_BITS'(QUARTER);
    sinOut = foldLookup(sinIdx);
    cosOut = foldLookup(cosIdx);
  end
endmodule

// File: rtl/ncoCarrier.sv
module ncoCarrier
  import ncoPkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int LUT_BITS = 6,
  parameter int AMP_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               sampleValid,
  input  logic [PHASE_W-1:0] initPhase,
  input  logic [PHASE_W-1:0] initStep,
  input  logic [PHASE_W-1:0] stepRate,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [AMP_W-1:0]   cosOut,
  output logic [AMP_W-1:0]   sinOut
);
  ncoStrobes_t        strobes;
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] stepQ;
  logic [PHASE_W-1:0] rateQ;

  ncoCtrl ctrl_i (
    .startPulse (startPulse),
    .sampleValid(sampleValid),
    .strobes    (strobes)
  );

  ncoPhaseDp #(.PHASE_W(PHASE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .initPhase(initPhase),
    .initStep (initStep),
    .stepRate (stepRate),
    .phaseQ   (phaseQ),
    .stepQ    (stepQ),
    .rateQ    (rateQ)
  );

  ncoSinCos #(.PHASE_W(PHASE_W), .LUT_BITS(LUT_BITS), .AMP_W(AMP_W)) lut_i (
    .phase (phaseQ),
    .cosOut(cosOut),
    .sinOut(sinOut)
  );

  assign phaseOut = phaseQ;
endmodule

// File: rtl/ncoCarrierChk.sv
module ncoCarrierChk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               startPulse,
  input logic               sampleValid,
  input logic [PHASE_W-1:0] initPhase,
  input logic [PHASE_W-1:0] initStep,
  input logic [PHASE_W-1:0] stepRate,
  input logic [PHASE_W-1:0] phaseOut,
  input logic [PHASE_W-1:0] stepCur,
  input logic [PHASE_W-1:0] rateCur,
  input logic [AMP_W-1:0]   cosOut,
  input logic [AMP_W-1:0]   sinOut
);
  localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (phaseOut == $past(initPhase)) && (stepCur == $past(initStep))
                   && (rateCur == $past(stepRate)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !startPulse) |=> phaseOut == $past(phaseOut + stepCur));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !startPulse) |=> $stable(phaseOut) && $stable(stepCur));

  p_chirp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !startPulse) |=> stepCur == $past(stepCur + rateCur));

  p_no_most_neg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinOut != MOST_NEG) && (cosOut != MOST_NEG));
endmodule

bind ncoCarrier ncoCarrierChk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .sampleValid(sampleValid),
  .initPhase  (initPhase),
  .initStep   (initStep),
  .stepRate   (stepRate),
  .phaseOut   (phaseOut),
  .stepCur    (stepQ),
  .rateCur    (rateQ),
  .cosOut     (cosOut),
  .sinOut     (sinOut)
);

// File: tb/ncoCarrier_tb_top.sv
module ncoCarrier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LUT_BITS   = 6;
  localparam int N_IDX      = 2 ** LUT_BITS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] initPhase = '0;
  logic [31:0] initStep = '0;
  logic [31:0] stepRate = '0;
  logic [31:0] phaseOut;
  logic [7:0]  cosOut;
  logic [7:0]  sinOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ncoCarrier #(.LUT_BITS(LUT_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sampleValid(sampleValid),
    .initPhase(initPhase), .initStep(initStep), .stepRate(stepRate),
    .phaseOut(phaseOut), .cosOut(cosOut), .sinOut(sinOut)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expTrig(input int idx, input bit isCos);
    real ang, v;
    int  r;
    ang = 6.283185307179586 * (real'(idx) + 0.5) / real'(N_IDX);
    v   = 127.0 * (isCos ? $cos(ang) : $sin(ang));
    r   = (v >= 0.0) ? $rtoi($floor(v + 0.5)) : -$rtoi($floor(-v + 0.5));
    return 8'(r);
  endfunction

  task automatic loadNco(input logic [31:0] p, input logic [31:0] s, input logic [31:0] r);
    @(negedge clk);
    initPhase = p; initStep = s; stepRate = r;
    startPulse = 1'b1; sampleValid = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic testReset();
    check32("R1 phase after reset", phaseOut, 32'h0);
  endtask

  task automatic testLoad();
    loadNco(32'h1234_5678, 32'h10, 32'h0);
    check32("R2 load phase", phaseOut, 32'h1234_5678);
  endtask

  task automatic testWrap();
    loadNco(32'h7FFF_FF00, 32'h200, 32'h0);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check32("R3 wrap past +pi", phaseOut, 32'h8000_0100);
    loadNco(32'h8000_0010, 32'hFFFF_FF00, 32'h0);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check32("R3 wrap past -pi", phaseOut, 32'h7FFF_FF10);
  endtask

  task automatic testChirp(input logic [31:0] p0, input logic [31:0] s0, input logic [31:0] r0);
    logic [31:0] p, s;
    p = p0; s = s0;
    loadNco(p0, s0, r0);
    sampleValid = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      p = p + s;
      s = s + r0;
      check32("R5 chirp phase", phaseOut, p);
    end
    sampleValid = 1'b0;
  endtask

  task automatic testHold();
    logic [31:0] p;
    loadNco(32'h0000_1000, 32'h100, 32'h40);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    p = 32'h0000_1100;
    check32("R3 first advance", phaseOut, p);
    repeat (5) @(negedge clk);
    check32("R4 phase held while idle", phaseOut, p);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check32("R4 step held while idle", phaseOut, p + 32'h140);
  endtask

  task automatic testPriority();
    loadNco(32'h0, 32'h1000, 32'h0);
    @(negedge clk);
    initPhase = 32'hABCD_0000; initStep = 32'h5; stepRate = 32'h0;
    startPulse = 1'b1; sampleValid = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check32("R2 start beats sample", phaseOut, 32'hABCD_0000);
    @(negedge clk);
    sampleValid = 1'b0;
    check32("R2 new step after priority load", phaseOut, 32'hABCD_0005);
  endtask

  task automatic testTable();
    for (int i = 0; i < N_IDX; i++) begin
      loadNco(32'(i) << (32 - LUT_BITS), 32'h0, 32'h0);
      check32("R6 sine table", {24'h0, sinOut}, {24'h0, expTrig(i, 1'b0)});
      check32("R6 cosine table", {24'h0, cosOut}, {24'h0, expTrig(i, 1'b1)});
      check32("R7 no most-negative code", {31'h0, (sinOut == 8'h80) || (cosOut == 8'h80)}, 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testWrap();
    testChirp(32'h0, 32'd1000, 32'd10);
    testChirp(32'h4000_0000, 32'hFFF0_0000, 32'hFFFF_F000);
    testHold();
    testPriority();
    testTable();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule